// File: doc/BRIEF.md
# Selectable-Timebase 16-bit Counter

This block is a free-running 16-bit up-counter for the system clock domain. Each advance of the counter is gated by a tick from one of six timebases: the raw system clock, two fixed system-clock prescalers, a pulse from a neighbouring timer's overflow, rising edges on an external count pin, or an asynchronous external oscillator. The pin and oscillator inputs are synchronized and edge-detected first. The oscillator's edges are then divided further. The counter is meant to serve as the shared time reference for a set of capture and compare channels, which are not part of this block.

A 3-bit selector picks the timebase. A run enable gates counting. A synchronous load presets the count. When the count wraps past its maximum, the block emits a one-cycle overflow pulse and sets a sticky overflow flag. That flag is cleared by writing a one to a clear input. When the selector changes, all prescalers restart, so the first tick from a newly chosen divided source arrives a full period later.

Top module: `timebase_counter`

## Requirements
- R1: During and right after reset, the count is 0 and both the overflow pulse and the sticky flag are 0.
- R2: With selector code 000 and run enabled, the count rises by one on every rising clock edge.
- R3: With code 001, the count rises by one every 4 clock edges.
- R4: With code 100, the count rises by one every 12 clock edges.
- R5: With code 010, the count rises by one for each clock cycle in which the timer-overflow input is high. The new value appears on the next clock edge.
- R6: With code 011, each rising edge of the count pin raises the count by one, on the third clock edge after the pin rises. A falling edge has no effect.
- R7: With code 101, the count rises by one for every 8 rising edges of the external oscillator, each edge taking the same three-edge synchronizer path as R6.
- R8: Codes 110 and 111 select no timebase, and the count holds while either is selected.
- R9: A change of selector restarts the prescalers. With code 001 chosen on a given edge, the first increment comes 4 edges after that edge, and with code 100 it comes 12 edges after it.
- R10: While run enable is low and no load is requested, the count holds.
- R11: A load request writes the load value into the count on the next edge and takes priority over a tick in that cycle.
- R12: When a tick takes the count from 0xFFFF to 0x0000, the overflow pulse is high for exactly the one cycle in which the count reads 0x0000.
- R13: The sticky flag sets together with the overflow pulse and stays set until a cycle with the clear input high. If an overflow and a clear occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enable |
| src_sel | input | 3 | Timebase selector code |
| ext_osc | input | 1 | Asynchronous external oscillator |
| t0_ovf | input | 1 | Overflow pulse from another timer |
| ext_cnt | input | 1 | Asynchronous external count pin |
| load_en | input | 1 | Synchronous load request |
| load_val | input | 16 | Value to load |
| ovf_clr | input | 1 | Write-one-to-clear for the sticky flag |
| count | output | 16 | Current count |
| ovf_pulse | output | 1 | One-cycle wrap indication |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
Loads and timer-overflow ticks show up one edge after they are applied. Pin and oscillator edges need three edges: two synchronizer flops and then the count register. A newly selected prescaled source first advances the count a full ratio of edges after the edge that registers the selector change. The bench changes inputs on falling edges and counts whole cycles before reading. For each path it samples one cycle before the increment is due and again at the cycle it is due, so a result that is one cycle early or late is caught.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      TB_SYS   = 3'b000,
      TB_DIVA  = 3'b001,
      TB_TOVF  = 3'b010,
      TB_PIN   = 3'b011,
      TB_DIVB  = 3'b100,
      TB_XOSC  = 3'b101,
      TB_OFF_A = 3'b110,
      TB_OFF_B = 3'b111
   } tb_src_e;
endpackage

// File: rtl/tb_prescaler.sv
module tb_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("tb_prescaler: DIV must be at least 2");
   end

   logic [W-1:0] cnt_q;

   assign tick = en && !clr && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
      end
   end

   // R9: a prescaler tick never repeats on the following cycle
   assert_tick_spaced_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R9: restarting the prescaler suppresses a tick in the next cycle
   assert_clr_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick);
endmodule

// File: rtl/tb_edge_sync.sv
module tb_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tb_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] && !last_q;

   // R6: a detected edge lasts exactly one cycle
   assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tb_count_core.sv
module tb_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             tick,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_pulse,
   output logic             ovf_flag
);
   if (CNT_W < 2) begin : g_bad_width
      $error("tb_count_core: CNT_W must be at least 2");
   end

   logic step;
   logic wrap;

   assign step = run_en && tick && !load_en;
   assign wrap = step && (&count);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count     <= '0;
         ovf_pulse <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         if (load_en)   count <= load_val;
         else if (step) count <= count + CNT_W'(1);
         ovf_pulse <= wrap;
         if (wrap)         ovf_flag <= 1'b1;
         else if (ovf_clr) ovf_flag <= 1'b0;
      end
   end

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !load_en) |=> $stable(count));
   assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (count == $past(load_val)));
   assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !load_en) |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));
   assert_pulse_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (count == '0));
   assert_pulse_short_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);
   assert_flag_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> ovf_flag);
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter #(
   parameter int CNT_W      = 16,
   parameter int DIV_A      = 4,
   parameter int DIV_B      = 12,
   parameter int DIV_XOSC   = 8,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [2:0]       src_sel,
   input  logic             ext_osc,
   input  logic             t0_ovf,
   input  logic             ext_cnt,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_pulse,
   output logic             ovf_flag
);
   import timebase_pkg::*;

   tb_src_e sel_q;
   logic    sel_chg;
   logic    tick_a, tick_b, tick_x;
   logic    pin_rise, osc_rise;
   logic    tick;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= TB_OFF_B;
      else        sel_q <= tb_src_e'(src_sel);
   end

   assign sel_chg = (src_sel != sel_q);

   tb_prescaler #(.DIV(DIV_A)) u_div_a (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .en(1'b1), .tick(tick_a));

   tb_prescaler #(.DIV(DIV_B)) u_div_b (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .en(1'b1), .tick(tick_b));

   tb_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync_pin (
      .clk(clk), .rst_n(rst_n), .async_in(ext_cnt), .rise(pin_rise));

   tb_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync_osc (
      .clk(clk), .rst_n(rst_n), .async_in(ext_osc), .rise(osc_rise));

   tb_prescaler #(.DIV(DIV_XOSC)) u_div_x (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .en(osc_rise), .tick(tick_x));

   always_comb begin
      case (tb_src_e'(src_sel))
         TB_SYS:  tick = 1'b1;
         TB_DIVA: tick = tick_a;
         TB_TOVF: tick = t0_ovf;
         TB_PIN:  tick = pin_rise;
         TB_DIVB: tick = tick_b;
         TB_XOSC: tick = tick_x;
         default: tick = 1'b0;
      endcase
   end

   tb_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
      .load_en(load_en), .load_val(load_val), .ovf_clr(ovf_clr),
      .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag));

   assert_off_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel[2:1] == 2'b11 && !load_en) |=> $stable(count));
   assert_sys_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == 3'b000 && run_en && !load_en) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: tb/sim_timebase_counter.sv
module sim_timebase_counter;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [2:0]  src_sel = 3'b111;
   logic        ext_osc = 1'b0;
   logic        t0_ovf = 1'b0;
   logic        ext_cnt = 1'b0;
   logic        load_en = 1'b0;
   logic [15:0] load_val = '0;
   logic        ovf_clr = 1'b0;
   logic [15:0] count;
   logic        ovf_pulse;
   logic        ovf_flag;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   timebase_counter u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
      .ext_osc(ext_osc), .t0_ovf(t0_ovf), .ext_cnt(ext_cnt),
      .load_en(load_en), .load_val(load_val), .ovf_clr(ovf_clr),
      .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic prep(input logic [15:0] v);
      @(negedge clk);
      src_sel = 3'b111; run_en = 1'b1; load_en = 1'b1; load_val = v;
      cyc(1);
      load_en = 1'b0;
      cyc(1);
   endtask

   task automatic t_reset();
      chk("R1 count", count, 0);
      chk("R1 pulse", ovf_pulse, 0);
      chk("R1 flag", ovf_flag, 0);
   endtask

   task automatic t_sys();
      prep(16'h0000);
      src_sel = 3'b000;
      cyc(10);
      chk("R2 every edge", count, 10);
   endtask

   task automatic t_div_a();
      prep(16'h0000);
      src_sel = 3'b001;
      cyc(4);
      chk("R9 first /4 not early", count, 0);
      cyc(1);
      chk("R9 first /4 due", count, 1);
      cyc(3);
      chk("R3 /4 not early", count, 1);
      cyc(1);
      chk("R3 /4 second", count, 2);
   endtask

   task automatic t_div_b();
      prep(16'h0000);
      src_sel = 3'b100;
      cyc(12);
      chk("R9 first /12 not early", count, 0);
      cyc(1);
      chk("R9 first /12 due", count, 1);
      cyc(12);
      chk("R4 /12 second", count, 2);
   endtask

   task automatic t_tovf();
      prep(16'h0010);
      src_sel = 3'b010;
      cyc(3);
      chk("R5 idle", count, 16'h10);
      for (int i = 0; i < 3; i++) begin
         t0_ovf = 1'b1;
         cyc(1);
         t0_ovf = 1'b0;
         chk("R5 per pulse", count, 16'h11 + i);
         cyc(2);
      end
   endtask

   task automatic t_pin();
      prep(16'h0100);
      src_sel = 3'b011;
      cyc(3);
      ext_cnt = 1'b1;
      cyc(2);
      chk("R6 not early", count, 16'h100);
      cyc(1);
      chk("R6 rise", count, 16'h101);
      ext_cnt = 1'b0;
      cyc(5);
      chk("R6 fall ignored", count, 16'h101);
      ext_cnt = 1'b1;
      cyc(5);
      chk("R6 second rise", count, 16'h102);
      ext_cnt = 1'b0;
      cyc(3);
   endtask

   task automatic osc_edges(input int n);
      for (int i = 0; i < n; i++) begin
         ext_osc = 1'b1;
         cyc(3);
         ext_osc = 1'b0;
         cyc(3);
      end
   endtask

   task automatic t_xosc();
      prep(16'h0200);
      src_sel = 3'b101;
      cyc(3);
      osc_edges(7);
      cyc(4);
      chk("R7 seven edges", count, 16'h200);
      osc_edges(1);
      cyc(4);
      chk("R7 eighth edge", count, 16'h201);
      osc_edges(8);
      cyc(4);
      chk("R7 sixteen edges", count, 16'h202);
   endtask

   task automatic t_off();
      prep(16'h1234);
      src_sel = 3'b110;
      t0_ovf = 1'b1; ext_cnt = 1'b1;
      cyc(6);
      t0_ovf = 1'b0; ext_cnt = 1'b0;
      osc_edges(9);
      chk("R8 code 110", count, 16'h1234);
      src_sel = 3'b111;
      cyc(15);
      chk("R8 code 111", count, 16'h1234);
   endtask

   task automatic t_run();
      prep(16'h0050);
      src_sel = 3'b000; run_en = 1'b0;
      cyc(10);
      chk("R10 hold", count, 16'h50);
      run_en = 1'b1;
      cyc(2);
      chk("R10 resume", count, 16'h52);
   endtask

   task automatic t_load();
      prep(16'h0000);
      src_sel = 3'b000;
      cyc(2);
      load_en = 1'b1; load_val = 16'hABCD;
      cyc(1);
      load_en = 1'b0;
      chk("R11 load over tick", count, 16'hABCD);
      cyc(1);
      chk("R11 after load", count, 16'hABCE);
   endtask

   task automatic t_ovf();
      prep(16'hFFFD);
      src_sel = 3'b000;
      cyc(2);
      chk("R12 no pulse yet", ovf_pulse, 0);
      cyc(1);
      chk("R12 wrap count", count, 0);
      chk("R12 pulse", ovf_pulse, 1);
      chk("R13 flag set", ovf_flag, 1);
      cyc(1);
      chk("R12 pulse one cycle", ovf_pulse, 0);
      chk("R13 flag sticky", ovf_flag, 1);
      src_sel = 3'b111;
      cyc(3);
      chk("R13 flag held", ovf_flag, 1);
      ovf_clr = 1'b1;
      cyc(1);
      ovf_clr = 1'b0;
      chk("R13 cleared", ovf_flag, 0);
      prep(16'hFFFF);
      src_sel = 3'b000; ovf_clr = 1'b1;
      cyc(1);
      ovf_clr = 1'b0;
      chk("R13 set beats clear", ovf_flag, 1);
      ovf_clr = 1'b1;
      cyc(1);
      ovf_clr = 1'b0;
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_sys();
      t_div_a();
      t_div_b();
      t_tovf();
      t_pin();
      t_xosc();
      t_off();
      t_run();
      t_load();
      t_ovf();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule